// File: doc/BRIEF.md
# Windowed Six-Bank Shared RAM

This block is a 3 KB byte-wide memory shared by two masters: an on-chip coprocessor and an 8-bit host CPU bus. The storage is split into six 512-byte dual-port banks. A one-hot read selector on each side picks which bank's registered output reaches that port. Either port may read or write any byte. The host side reaches the memory through a 4 KB window in its 64 KB address space. The window is qualified by the host bus-phase signal.

On the host side, the block also steers the host read-data bus. Inside the window it returns memory data. Outside the window it passes through the data from the external ROM/work-RAM path. The block adds a window-read term to the host output-enable, which is otherwise formed from the existing work-RAM, program-RAM and configuration-read enables.

The host port works on the rising edge of the system clock. The coprocessor port presents its address on the falling edge, where its read data and write request are captured. Both ports commit their writes at the following rising edge, and the coprocessor write is applied last.

Top module: `hwram_top`

## Requirements
- R1: A host access hits the window only when `host_phase` is 1 and `host_addr[15:12]` equals 4'h5. The window offset is `host_addr[11:0]`.
- R2: While the host address hits the window, `host_rdata` carries memory read data. Otherwise it equals `ext_rdata` in the same cycle.
- R3: `host_oe` is high exactly when any of `wram_oe`, `prgram_oe` or `cfg_rd_oe` is high, or when a window hit occurs with `host_we` low.
- R4: A host window write with `host_we`=1 stores `host_wdata` at the rising edge. A host window read returns the byte as it stood before that edge's writes (read-first). A write is therefore visible one cycle later.
- R5: The coprocessor port samples `cop_addr`, `cop_wdata` and the active-low `cop_we_n` at the falling edge. `cop_rdata` shows the addressed byte from that falling edge onward. A write commits at the next rising edge.
- R6: Offsets 0x000 to 0xBFF form one 3 KB store of six 512-byte banks, chosen by offset bits [11:9] = 0..5. A byte written by either port is read back by the other.
- R7: Offsets 0xC00 to 0xFFF hold no storage. Reads there return 8'h00 on both ports, and writes there change nothing.
- R8: When both ports write the same byte in the same cycle, the coprocessor's data is kept.
- R9: Host writes outside the window (phase low or a different page) leave the memory unchanged.
- R10: While `cop_rst` is high, `cop_rdata` reads 8'h00 and no coprocessor write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; host side on rising edge, coprocessor side on falling edge |
| rst_n | input | 1 | Active-low reset of the host-side read selector |
| host_phase | input | 1 | Host bus-phase qualifier |
| host_addr | input | 16 | Host address |
| host_we | input | 1 | Host write enable, active high |
| host_wdata | input | 8 | Host write data |
| ext_rdata | input | 8 | Read data from the external ROM/work-RAM path |
| wram_oe | input | 1 | Existing work-RAM output-enable term |
| prgram_oe | input | 1 | Existing program-RAM output-enable term |
| cfg_rd_oe | input | 1 | Existing configuration-read output-enable term |
| host_rdata | output | 8 | Steered host read data |
| host_oe | output | 1 | Combined host output enable |
| cop_rst | input | 1 | Coprocessor port reset, active high |
| cop_addr | input | 12 | Coprocessor byte address |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_we_n | input | 1 | Coprocessor write enable, active low |
| cop_rdata | output | 8 | Coprocessor read data |

## Verification
`host_oe` and the steering choice between memory and `ext_rdata` are combinational, so they are due in the same cycle as the host inputs. Host read data is due after one rising edge. Coprocessor read data is due half a cycle after its inputs, at the falling edge. Writes from either port become visible to both ports at the rising edge that follows. The bench drives every input 1 ns after a rising edge and samples all three outputs 0.5 ns after the next rising edge. Each cycle's reads are checked against the reference array as it stood before that cycle's writes, and the writes are applied to the array only afterwards, host first and then coprocessor.

// File: rtl/hwram_pkg.sv
package hwram_pkg;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_ADDR_W    = 16;
  localparam int unsigned DEF_WIN_AW    = 12;
  localparam int unsigned DEF_BANK_AW   = 9;
  localparam int unsigned DEF_NUM_BANKS = 6;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  // Classifies a host cycle from its window hit and write flag.
  function automatic acc_kind_t classify(input logic hit, input logic we);
    if (!hit)    return ACC_IDLE;
    else if (we) return ACC_WRITE;
    else         return ACC_READ;
  endfunction
endpackage

// File: rtl/hwram_decode.sv
module hwram_decode
  import hwram_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned WIN_AW = DEF_WIN_AW,
  parameter logic [ADDR_W-WIN_AW-1:0] WIN_PAGE = 'h5
) (
  input  logic              phase,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              hit,
  output acc_kind_t         kind,
  output logic [WIN_AW-1:0] offset
);
  logic [ADDR_W-WIN_AW-1:0] page;

  assign page   = addr[ADDR_W-1:WIN_AW];
  assign hit    = phase && (page == WIN_PAGE);
  assign kind   = classify(hit, we);
  assign offset = addr[WIN_AW-1:0];
endmodule

// File: rtl/hwram_split.sv
module hwram_split #(
  parameter int unsigned WIN_AW    = 12,
  parameter int unsigned BANK_AW   = 9,
  parameter int unsigned NUM_BANKS = 6
) (
  input  logic [WIN_AW-1:0]    offset,
  output logic [NUM_BANKS-1:0] sel_oh,
  output logic                 in_range
);
  localparam int unsigned IDX_W = WIN_AW - BANK_AW;

  logic [IDX_W-1:0] idx;

  assign idx      = offset[WIN_AW-1:BANK_AW];
  assign in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_BANKS));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    assign sel_oh[i] = in_range && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/hwram_bank.sv
module hwram_bank #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned BANK_AW = 9
) (
  input  logic               clk,
  input  logic [BANK_AW-1:0] a_addr,
  input  logic               a_we,
  input  logic [DATA_W-1:0]  a_din,
  output logic [DATA_W-1:0]  a_q,
  input  logic [BANK_AW-1:0] b_raddr,
  output logic [DATA_W-1:0]  b_q,
  input  logic [BANK_AW-1:0] b_waddr,
  input  logic               b_we,
  input  logic [DATA_W-1:0]  b_din
);
  localparam int unsigned DEPTH = 1 << BANK_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single writer: side B is applied after side A, so it wins a collision.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_din;
    if (b_we) mem[b_waddr] <= b_din;
    a_q <= mem[a_addr];
  end

  always_ff @(negedge clk) begin
    b_q <= mem[b_raddr];
  end
endmodule

// File: rtl/hwram_rdmux.sv
module hwram_rdmux #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BANKS = 6
) (
  input  logic [NUM_BANKS-1:0]             sel_oh,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q,
  output logic [DATA_W-1:0]                dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      dout = dout | (bank_q[i] & {DATA_W{sel_oh[i]}});
    end
  end
endmodule

// File: rtl/hwram_top.sv
module hwram_top
  import hwram_pkg::*;
#(
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned WIN_AW    = DEF_WIN_AW,
  parameter int unsigned BANK_AW   = DEF_BANK_AW,
  parameter int unsigned NUM_BANKS = DEF_NUM_BANKS,
  parameter logic [ADDR_W-WIN_AW-1:0] WIN_PAGE = 'h5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_phase,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              wram_oe,
  input  logic              prgram_oe,
  input  logic              cfg_rd_oe,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_oe,
  input  logic              cop_rst,
  input  logic [WIN_AW-1:0] cop_addr,
  input  logic [DATA_W-1:0] cop_wdata,
  input  logic              cop_we_n,
  output logic [DATA_W-1:0] cop_rdata
);
  // Host window decode
  logic              h_hit;
  acc_kind_t         h_kind;
  logic [WIN_AW-1:0] h_off;

  hwram_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .WIN_PAGE(WIN_PAGE)) u_dec (
    .phase(host_phase), .addr(host_addr), .we(host_we),
    .hit(h_hit), .kind(h_kind), .offset(h_off)
  );

  // Bank selection for both sides
  logic [NUM_BANKS-1:0] h_sel_oh, c_sel_oh;
  logic                 h_inr, c_inr;

  hwram_split #(.WIN_AW(WIN_AW), .BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS)) u_hsplit (
    .offset(h_off), .sel_oh(h_sel_oh), .in_range(h_inr)
  );
  hwram_split #(.WIN_AW(WIN_AW), .BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS)) u_csplit (
    .offset(cop_addr), .sel_oh(c_sel_oh), .in_range(c_inr)
  );

  // Coprocessor side: captured on the falling edge
  logic                 pend_we;
  logic [BANK_AW-1:0]   pend_addr;
  logic [DATA_W-1:0]    pend_din;
  logic [NUM_BANKS-1:0] pend_oh;
  logic [NUM_BANKS-1:0] c_sel_q;

  always_ff @(negedge clk) begin
    if (cop_rst) begin
      pend_we <= 1'b0;
      pend_oh <= '0;
      c_sel_q <= '0;
    end else begin
      pend_we <= !cop_we_n && c_inr;
      pend_oh <= c_sel_oh;
      c_sel_q <= c_sel_oh;
    end
    pend_addr <= cop_addr[BANK_AW-1:0];
    pend_din  <= cop_wdata;
  end

  // Host side: read selector registered with the read
  logic [NUM_BANKS-1:0] h_sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) h_sel_q <= '0;
    else        h_sel_q <= h_sel_oh;
  end

  // Per-bank write strobes, brought out for the checker
  logic [NUM_BANKS-1:0] h_bank_we, c_bank_we;
  logic                 h_wr_ok;

  assign h_wr_ok = (h_kind == ACC_WRITE) && h_inr;

  logic [NUM_BANKS-1:0][DATA_W-1:0] a_q_all, b_q_all;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign h_bank_we[i] = h_wr_ok && h_sel_oh[i];
    assign c_bank_we[i] = pend_we && pend_oh[i];

    hwram_bank #(.DATA_W(DATA_W), .BANK_AW(BANK_AW)) u_bank (
      .clk    (clk),
      .a_addr (h_off[BANK_AW-1:0]),
      .a_we   (h_bank_we[i]),
      .a_din  (host_wdata),
      .a_q    (a_q_all[i]),
      .b_raddr(cop_addr[BANK_AW-1:0]),
      .b_q    (b_q_all[i]),
      .b_waddr(pend_addr),
      .b_we   (c_bank_we[i]),
      .b_din  (pend_din)
    );
  end

  // Output selection
  logic [DATA_W-1:0] host_word;

  hwram_rdmux #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_hmux (
    .sel_oh(h_sel_q), .bank_q(a_q_all), .dout(host_word)
  );
  hwram_rdmux #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_cmux (
    .sel_oh(c_sel_q), .bank_q(b_q_all), .dout(cop_rdata)
  );

  assign host_rdata = h_hit ? host_word : ext_rdata;
  assign host_oe    = wram_oe | prgram_oe | cfg_rd_oe | (h_kind == ACC_READ);
endmodule

// File: rtl/hwram_chk.sv
module hwram_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_AW    = 12,
  parameter int unsigned BANK_AW   = 9,
  parameter int unsigned NUM_BANKS = 6,
  parameter logic [ADDR_W-WIN_AW-1:0] WIN_PAGE = 'h5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 host_phase,
  input logic [ADDR_W-1:0]    host_addr,
  input logic                 host_we,
  input logic [DATA_W-1:0]    ext_rdata,
  input logic [DATA_W-1:0]    host_rdata,
  input logic                 wram_oe,
  input logic                 prgram_oe,
  input logic                 cfg_rd_oe,
  input logic                 host_oe,
  input logic                 cop_rst,
  input logic                 pend_we,
  input logic [DATA_W-1:0]    host_word,
  input logic [NUM_BANKS-1:0] h_bank_we,
  input logic [NUM_BANKS-1:0] c_bank_we
);
  logic in_win, oor;

  assign in_win = host_phase && (host_addr[ADDR_W-1:WIN_AW] == WIN_PAGE);
  assign oor    = int'(host_addr[WIN_AW-1:BANK_AW]) >= int'(NUM_BANKS);

  assert_steer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (host_rdata == ext_rdata));

  assert_oe_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !host_we) |-> host_oe);

  assert_oe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wram_oe && !prgram_oe && !cfg_rd_oe && !host_phase) |-> !host_oe);

  assert_oor_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && oor) |=> (host_word == '0));

  assert_oor_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && oor) |-> (h_bank_we == '0));

  assert_outside_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (h_bank_we == '0));

  assert_one_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(h_bank_we) && $onehot0(c_bank_we));

  assert_coprst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cop_rst |-> !pend_we);
endmodule

bind hwram_top hwram_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_AW(WIN_AW),
  .BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS), .WIN_PAGE(WIN_PAGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_phase(host_phase), .host_addr(host_addr),
  .host_we(host_we), .ext_rdata(ext_rdata), .host_rdata(host_rdata),
  .wram_oe(wram_oe), .prgram_oe(prgram_oe), .cfg_rd_oe(cfg_rd_oe),
  .host_oe(host_oe), .cop_rst(cop_rst), .pend_we(pend_we),
  .host_word(host_word), .h_bank_we(h_bank_we), .c_bank_we(c_bank_we)
);

// File: tb/sim_hwram_top.sv
`timescale 1ns/100ps
module sim_hwram_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_phase, host_we, wram_oe, prgram_oe, cfg_rd_oe;
  logic [15:0] host_addr;
  logic [7:0]  host_wdata, ext_rdata, host_rdata, cop_wdata, cop_rdata;
  logic        host_oe, cop_rst, cop_we_n;
  logic [11:0] cop_addr;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [3072];

  always #2 clk = ~clk;

  hwram_top u0 (
    .clk(clk), .rst_n(rst_n), .host_phase(host_phase), .host_addr(host_addr),
    .host_we(host_we), .host_wdata(host_wdata), .ext_rdata(ext_rdata),
    .wram_oe(wram_oe), .prgram_oe(prgram_oe), .cfg_rd_oe(cfg_rd_oe),
    .host_rdata(host_rdata), .host_oe(host_oe), .cop_rst(cop_rst),
    .cop_addr(cop_addr), .cop_wdata(cop_wdata), .cop_we_n(cop_we_n),
    .cop_rdata(cop_rdata)
  );

  function automatic logic [7:0] peek(input int off);
    if (off >= 3072) return 8'h00;   // R7: no storage above 0xBFF
    return model[off];
  endfunction

  task automatic check8(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: called 1 ns after a rising edge, returns 1 ns after the next.
  task automatic cyc(input string tag, input bit ph, input logic [15:0] ha,
                     input bit hwe, input logic [7:0] hd, input bit crst,
                     input logic [11:0] ca, input bit cwen, input logic [7:0] cd);
    bit         hit;
    logic [7:0] exp_h, exp_c;
    bit         exp_oe;
    host_phase = ph; host_addr = ha; host_we = hwe; host_wdata = hd;
    cop_rst = crst; cop_addr = ca; cop_we_n = cwen; cop_wdata = cd;
    ext_rdata = 8'($urandom);
    wram_oe = ($urandom % 4) == 0;
    prgram_oe = ($urandom % 4) == 0;
    cfg_rd_oe = ($urandom % 4) == 0;
    hit    = ph && (ha[15:12] == 4'h5);                    // R1
    exp_h  = hit ? peek(int'(ha[11:0])) : ext_rdata;        // R2, R4
    exp_c  = crst ? 8'h00 : peek(int'(ca));                 // R5, R10
    exp_oe = wram_oe | prgram_oe | cfg_rd_oe | (hit && !hwe); // R3
    @(posedge clk);
    #0.5;
    check8(tag, "host_rdata", host_rdata, exp_h);
    check8(tag, "cop_rdata", cop_rdata, exp_c);
    check8(tag, "host_oe", {7'd0, host_oe}, {7'd0, exp_oe});
    // Commit: host first, coprocessor last (R8)
    if (hit && hwe && ha[11:0] < 12'hC00) model[ha[11:0]] = hd;  // R4, R9
    if (!crst && !cwen && ca < 12'hC00) model[ca] = cd;          // R5, R7
    #0.5;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cop_rst = 1'b1; host_phase = 1'b0; host_addr = 16'h0;
    host_we = 1'b0; host_wdata = 8'h0; ext_rdata = 8'h3C; wram_oe = 1'b0;
    prgram_oe = 1'b0; cfg_rd_oe = 1'b0; cop_addr = 12'h0; cop_we_n = 1'b1;
    cop_wdata = 8'h0;
    repeat (4) @(posedge clk);
    #0.5;
    // Reset state: R2 pass-through, R10 zero read, R3 idle enable
    check8("R2", "reset host_rdata", host_rdata, 8'h3C);
    check8("R10", "reset cop_rdata", cop_rdata, 8'h00);
    check8("R3", "reset host_oe", {7'd0, host_oe}, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Fill every byte through the coprocessor port (R5, R6)
    for (int a = 0; a < 3072; a++)
      cyc("R5", 1'b0, 16'h0000, 1'b0, 8'h00, 1'b0, 12'(a), 1'b0, 8'((a * 7) ^ (a >> 4)));

    // R1: window qualification
    cyc("R1", 1'b0, 16'h5010, 1'b0, 8'h00, 1'b0, 12'h000, 1'b1, 8'h00);
    cyc("R1", 1'b1, 16'h4010, 1'b0, 8'h00, 1'b0, 12'h000, 1'b1, 8'h00);
    cyc("R1", 1'b1, 16'h6010, 1'b0, 8'h00, 1'b0, 12'h000, 1'b1, 8'h00);
    cyc("R1", 1'b1, 16'h5010, 1'b0, 8'h00, 1'b0, 12'h000, 1'b1, 8'h00);
    // R4: read-first on same-cycle write, then readback
    cyc("R4", 1'b1, 16'h5123, 1'b1, 8'hAA, 1'b0, 12'h000, 1'b1, 8'h00);
    cyc("R4", 1'b1, 16'h5123, 1'b0, 8'h00, 1'b0, 12'h123, 1'b1, 8'h00);
    // R5 / R6: coprocessor write, host sees it; bank edges
    cyc("R5", 1'b0, 16'h0000, 1'b0, 8'h00, 1'b0, 12'h200, 1'b0, 8'h55);
    cyc("R6", 1'b1, 16'h5200, 1'b0, 8'h00, 1'b0, 12'h200, 1'b1, 8'h00);
    cyc("R6", 1'b1, 16'h51FF, 1'b1, 8'h11, 1'b0, 12'hBFF, 1'b0, 8'h22);
    cyc("R6", 1'b1, 16'h5BFF, 1'b0, 8'h00, 1'b0, 12'h1FF, 1'b1, 8'h00);
    // R7: no storage at 0xC00..0xFFF
    cyc("R7", 1'b1, 16'h5C00, 1'b1, 8'h77, 1'b0, 12'hFFF, 1'b0, 8'h88);
    cyc("R7", 1'b1, 16'h5C00, 1'b0, 8'h00, 1'b0, 12'hFFF, 1'b1, 8'h00);
    cyc("R7", 1'b1, 16'h5000, 1'b0, 8'h00, 1'b0, 12'h3FF, 1'b1, 8'h00);
    // R8: same byte, same cycle
    cyc("R8", 1'b1, 16'h5300, 1'b1, 8'h12, 1'b0, 12'h300, 1'b0, 8'h34);
    cyc("R8", 1'b1, 16'h5300, 1'b0, 8'h00, 1'b0, 12'h300, 1'b1, 8'h00);
    // R9: writes outside the window are ignored
    cyc("R9", 1'b0, 16'h5050, 1'b1, 8'hE1, 1'b0, 12'h000, 1'b1, 8'h00);
    cyc("R9", 1'b1, 16'h6050, 1'b1, 8'hE2, 1'b0, 12'h000, 1'b1, 8'h00);
    cyc("R9", 1'b1, 16'h5050, 1'b0, 8'h00, 1'b0, 12'h050, 1'b1, 8'h00);
    // R10: coprocessor reset blocks writes and zeroes read data
    cyc("R10", 1'b0, 16'h0000, 1'b0, 8'h00, 1'b1, 12'h060, 1'b0, 8'hC3);
    cyc("R10", 1'b1, 16'h5060, 1'b0, 8'h00, 1'b0, 12'h060, 1'b1, 8'h00);
    // Random interleaving (R2, R3, R4, R5, R6, R7, R8)
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] ha;
      logic [11:0] ca;
      ha = {(($urandom % 4) != 0) ? 4'h5 : 4'($urandom), 12'($urandom % 3300)};
      ca = (($urandom % 8) == 0) ? ha[11:0] : 12'($urandom % 3300);
      cyc("R6", ($urandom % 8) != 0, ha, ($urandom % 3) == 0, 8'($urandom),
          ($urandom % 50) == 0, ca, ($urandom % 3) != 0, 8'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule